// File: doc/BRIEF.md
# Multi-mode clock-data-frame serializer

This block turns parallel sample words from a bank of converter channels into serial bit streams, one per output lane, and generates the frame clock and bit clock that a receiver uses to recover them. It runs in one fast clock domain in which one cycle is one serial bit time. Each word holds 10, 12, 14 or 16 valid bits, selected by a static code. The bit clock is double data rate: every edge of it, rising or falling, marks a new serial bit.

In single-rate mode every lane carries exactly one channel per frame. In double-rate mode two neighbouring channels share one lane, one word after the other. Only the first half of each group of eight lanes carries data. The remaining lanes raise an idle flag and hold their output low. The frame clock keeps the same period in both modes, so in double-rate mode each frame holds twice as many bit times. Bit order can be set to least-significant first (the default) or most-significant first.

A small state machine steps through each frame. ST_HALT is the reset state, with every output low. ST_FIRST shifts the first word of the frame, and ST_SECOND shifts the second word in double-rate mode. The transitions are:
- HALT to FIRST on the first cycle after reset.
- FIRST to FIRST at the end of a single-rate frame.
- FIRST to SECOND at the end of the first word in double-rate mode.
- SECOND to FIRST at the end of a double-rate frame.

Both the sample words and the configuration are captured on every entry to ST_FIRST at bit position 0.

Top module: `cdfs_serializer`

## Requirements
- R1: `cfg_width` codes 0, 1, 2 and 3 select 10, 12, 14 and 16 bits per word (F). Word bits at or above F never reach a lane.
- R2: With `cfg_two_x`=0, a frame lasts F bit times. Lane k (0-based) carries bits of channel k, and `lane_idle` is all zero.
- R3: With `cfg_two_x`=1, a frame lasts 2F bit times. Within each group of eight lanes (base B), lane B+m for m<4 carries channel B+2m during the first F bit times and then channel B+2m+1.
- R4: With `cfg_two_x`=1, lanes B+4 to B+7 of each group have `lane_idle`=1 and `lane_out`=0 for the whole frame. With 16 channels, `lane_idle` is 0xF0F0.
- R5: With `cfg_msb_first`=0, word bit i is sent at word position i. With `cfg_msb_first`=1, bit F-1-i is sent instead. In double-rate mode the order applies to each word on its own.
- R6: `bit_clk` is 1 at even frame positions and 0 at odd ones. This gives F/2 bit-clock periods per frame in single-rate mode and F periods in double-rate mode.
- R7: `frame_clk` is 1 for the first half of the frame's bit times and 0 for the second half. It rises together with the first bit of each frame.
- R8: `ch_words` is captured only at the first bit time of a frame. Changes later in the frame do not affect the words being sent.
- R9: Changes to `cfg_width`, `cfg_two_x` or `cfg_msb_first` take effect only at the next frame boundary.
- R10: While `rst` is high, all outputs are 0. The first frame begins at the first clock edge after `rst` falls, with position 0 visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one cycle per serial bit |
| rst | input | 1 | Synchronous reset, active high |
| cfg_width | input | 2 | Bits-per-word code (10/12/14/16) |
| cfg_two_x | input | 1 | 1 selects double-rate packing |
| cfg_msb_first | input | 1 | 1 selects most-significant-bit-first order |
| ch_words | input | NCH*16 | Channel words, channel c at bits [16c+15:16c] |
| lane_out | output | NCH | Serial data, one bit per lane |
| lane_idle | output | NCH | Lane is unused in the current mode |
| frame_clk | output | 1 | Frame clock |
| bit_clk | output | 1 | Double-data-rate bit clock |

## Verification
Two things can land on the same cycle: the frame-boundary capture and a change of inputs or configuration. The bench applies new words and a new configuration during the last bit of a frame, just before the capture edge. It then overwrites both with random values at the second bit of the frame. Every bit position is compared with a bench model that uses only the values captured at the boundary, so a late capture or a mid-frame leak shows up as a lane, idle-flag or clock mismatch. A reset is also asserted in the middle of a frame to confirm that framing restarts cleanly.

// File: rtl/cdfs_pkg.sv
package cdfs_pkg;
    parameter int WORD_MAX = 16;
    localparam int IDX_W = $clog2(WORD_MAX + 1);
    localparam int BIT_W = $clog2(WORD_MAX);

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [1:0] width_code;
        logic       two_x;
        logic       msb_first;
    } ser_cfg_t;

    // bits per word for a width code: 10, 12, 14, 16
    function automatic logic [IDX_W-1:0] word_bits(input logic [1:0] code);
        return IDX_W'(10 + 2 * int'(code));
    endfunction
endpackage

// File: rtl/cdfs_hold.sv
module cdfs_hold
    import cdfs_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cap,
    input  logic [NCH*WORD_MAX-1:0] d_in,
    output logic [NCH*WORD_MAX-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (cap) q <= d_in;
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(q));
endmodule

// File: rtl/cdfs_sequencer.sv
module cdfs_sequencer
    import cdfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ser_cfg_t         cfg_in,
    output seq_state_e       state_o,
    output logic [IDX_W-1:0] idx_o,
    output ser_cfg_t         cfg_o,
    output logic             capture_o,
    output logic             frame_clk,
    output logic             bit_clk
);
    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    ser_cfg_t         cfg_q;
    logic [IDX_W-1:0] width;
    logic             last_bit;
    logic             cap;

    assign width    = word_bits(cfg_q.width_code);
    assign last_bit = (idx_q == width - IDX_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q + IDX_W'(1);
        cap     = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                state_d = ST_FIRST;
                idx_d   = '0;
                cap     = 1'b1;
            end
            ST_FIRST: begin
                if (last_bit) begin
                    idx_d = '0;
                    if (cfg_q.two_x) begin
                        state_d = ST_SECOND;
                    end else begin
                        state_d = ST_FIRST;
                        cap     = 1'b1;
                    end
                end
            end
            ST_SECOND: begin
                if (last_bit) begin
                    state_d = ST_FIRST;
                    idx_d   = '0;
                    cap     = 1'b1;
                end
            end
            default: begin
                state_d = ST_HALT;
                idx_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HALT;
            idx_q   <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (cap) cfg_q <= cfg_in;
        end
    end

    // outputs
    always_comb begin
        frame_clk = 1'b0;
        bit_clk   = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                frame_clk = 1'b0;
                bit_clk   = 1'b0;
            end
            ST_FIRST: begin
                frame_clk = cfg_q.two_x ? 1'b1 : (idx_q < (width >> 1));
                bit_clk   = ~idx_q[0];
            end
            ST_SECOND: begin
                frame_clk = 1'b0;
                bit_clk   = ~idx_q[0];
            end
            default: begin
                frame_clk = 1'b0;
                bit_clk   = 1'b0;
            end
        endcase
    end

    assign state_o   = state_q;
    assign idx_o     = idx_q;
    assign cfg_o     = cfg_q;
    assign capture_o = cap;

    // R6
    bclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_HALT && $past(state_q) != ST_HALT) |-> (bit_clk != $past(bit_clk)));
    // R7
    fclk_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_clk) |-> (state_q == ST_FIRST && idx_q == '0));
    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(cfg_q));
    // R3
    second_word_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SECOND) |-> cfg_q.two_x);
    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_HALT) |-> (idx_q < width));
endmodule

// File: rtl/cdfs_lane_mux.sv
module cdfs_lane_mux
    import cdfs_pkg::*;
#(
    parameter int NCH = 16
) (
    input  seq_state_e       state,
    input  logic [IDX_W-1:0] idx,
    input  ser_cfg_t         cfg,
    input  logic [WORD_MAX-1:0] words [NCH],
    output logic [NCH-1:0]   lane_out,
    output logic [NCH-1:0]   lane_idle
);
    localparam int GRP   = NCH / 2;
    localparam int PAIRS = GRP / 2;

    logic [IDX_W-1:0] width;
    logic [IDX_W-1:0] pos;
    logic [BIT_W-1:0] bsel;
    logic             active;

    always_comb begin
        width  = word_bits(cfg.width_code);
        pos    = cfg.msb_first ? (width - IDX_W'(1) - idx) : idx;
        bsel   = pos[BIT_W-1:0];
        active = (state != ST_HALT);
    end

    for (genvar k = 0; k < NCH; k++) begin : g_lane
        localparam int  GI     = k / GRP;
        localparam int  MI     = k % GRP;
        localparam bit  PAIRED = (MI < PAIRS);
        localparam int  CH_A   = PAIRED ? (GI * GRP + 2 * MI) : k;
        localparam int  CH_B   = PAIRED ? (CH_A + 1) : k;

        logic [WORD_MAX-1:0] src;
        logic                idle;

        always_comb begin
            if (!cfg.two_x)              src = words[k];
            else if (state == ST_SECOND) src = words[CH_B];
            else                         src = words[CH_A];
        end

        assign idle         = active && cfg.two_x && !PAIRED;
        assign lane_idle[k] = idle;
        assign lane_out[k]  = active && !idle && src[bsel];
    end
endmodule

// File: rtl/cdfs_serializer.sv
module cdfs_serializer
    import cdfs_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              cfg_width,
    input  logic                    cfg_two_x,
    input  logic                    cfg_msb_first,
    input  logic [NCH*WORD_MAX-1:0] ch_words,
    output logic [NCH-1:0]          lane_out,
    output logic [NCH-1:0]          lane_idle,
    output logic                    frame_clk,
    output logic                    bit_clk
);
    ser_cfg_t               cfg_in, cfg_q;
    seq_state_e             state;
    logic [IDX_W-1:0]       idx;
    logic                   capture;
    logic [NCH*WORD_MAX-1:0] held;
    logic [WORD_MAX-1:0]    words [NCH];

    assign cfg_in = '{width_code: cfg_width, two_x: cfg_two_x, msb_first: cfg_msb_first};

    cdfs_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .cfg_in    (cfg_in),
        .state_o   (state),
        .idx_o     (idx),
        .cfg_o     (cfg_q),
        .capture_o (capture),
        .frame_clk (frame_clk),
        .bit_clk   (bit_clk)
    );

    cdfs_hold #(.NCH(NCH)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .cap  (capture),
        .d_in (ch_words),
        .q    (held)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_unpack
        assign words[c] = held[c*WORD_MAX +: WORD_MAX];
    end

    cdfs_lane_mux #(.NCH(NCH)) u_mux (
        .state     (state),
        .idx       (idx),
        .cfg       (cfg_q),
        .words     (words),
        .lane_out  (lane_out),
        .lane_idle (lane_idle)
    );

    // R4
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SECOND) |-> ($countones(lane_idle) == NCH / 2));
    // R2
    onex_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_HALT && !cfg_q.two_x) |-> (lane_idle == '0));
    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |-> (lane_out == '0 && !frame_clk && !bit_clk));
endmodule

// File: tb/cdfs_serializer_test.sv
`timescale 1ns/1ps
module cdfs_serializer_test;
    localparam int NCH = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic [1:0]       cfg_width;
    logic             cfg_two_x;
    logic             cfg_msb_first;
    logic [NCH*16-1:0] ch_words;
    logic [NCH-1:0]   lane_out, lane_idle;
    logic             frame_clk, bit_clk;

    int total = 0;
    int bad   = 0;

    logic [1:0]        cur_code;
    logic              cur_two, cur_msb;
    logic [NCH*16-1:0] cur_data;

    always #4 clk = ~clk;

    cdfs_serializer #(.NCH(NCH)) uut (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_two_x(cfg_two_x),
        .cfg_msb_first(cfg_msb_first), .ch_words(ch_words), .lane_out(lane_out),
        .lane_idle(lane_idle), .frame_clk(frame_clk), .bit_clk(bit_clk)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int fbits();
        return 10 + 2 * int'(cur_code);
    endfunction

    function automatic logic [NCH-1:0] exp_lanes(input int p);
        int f;
        logic [NCH-1:0] r;
        f = fbits();
        r = '0;
        for (int k = 0; k < NCH; k++) begin
            int ch, i, b, g, m;
            g = k / (NCH / 2);
            m = k % (NCH / 2);
            if (!cur_two) begin
                ch = k; i = p;
            end else begin
                if (m >= NCH / 4) continue;
                ch = g * (NCH / 2) + 2 * m + ((p >= f) ? 1 : 0);
                i = p % f;
            end
            b = cur_msb ? (f - 1 - i) : i;
            r[k] = cur_data[ch*16 + b];
        end
        return r;
    endfunction

    function automatic logic [NCH-1:0] exp_idle();
        logic [NCH-1:0] r;
        r = '0;
        for (int k = 0; k < NCH; k++)
            if (cur_two && (k % (NCH / 2)) >= NCH / 4) r[k] = 1'b1;
        return r;
    endfunction

    // pick and drive the configuration and words for frame number f
    task automatic next_cfg(input int f);
        if (f < 16) begin
            cur_code = f[1:0]; cur_two = f[2]; cur_msb = f[3];
        end else begin
            cur_code = 2'($urandom_range(0, 3));
            cur_two  = 1'($urandom_range(0, 1));
            cur_msb  = 1'($urandom_range(0, 1));
        end
        for (int w = 0; w < NCH / 2; w++) cur_data[w*32 +: 32] = $urandom;
        if (f % 5 == 0) cur_data = {(NCH / 2){32'hA5C3_F00F}};
        cfg_width = cur_code; cfg_two_x = cur_two; cfg_msb_first = cur_msb;
        ch_words = cur_data;
    endtask

    task automatic run_frame(input int f);
        int len;
        string ltag;
        len  = cur_two ? 2 * fbits() : fbits();
        ltag = cur_two ? "R3 R1 R5 R8 R9" : "R2 R1 R5 R8 R9";
        for (int p = 0; p < len; p++) begin
            @(posedge clk); #2;
            chk(ltag, "lane_out", 32'(lane_out), 32'(exp_lanes(p)));
            chk(cur_two ? "R4" : "R2", "lane_idle", 32'(lane_idle), 32'(exp_idle()));
            chk("R7", "frame_clk", 32'(frame_clk), 32'(p < len / 2));
            chk("R6", "bit_clk", 32'(bit_clk), 32'((p % 2) == 0));
            if (p == 1) begin
                // mid-frame disturbance must not reach the current frame
                ch_words      = {(NCH / 2){$urandom}};
                cfg_width     = ~cur_code;
                cfg_two_x     = ~cur_two;
                cfg_msb_first = ~cur_msb;
            end
            if (p == len - 1) next_cfg(f + 1);
        end
    endtask

    task automatic chk_quiet();
        chk("R10", "lane_out", 32'(lane_out), 32'd0);
        chk("R10", "lane_idle", 32'(lane_idle), 32'd0);
        chk("R10", "frame_clk", 32'(frame_clk), 32'd0);
        chk("R10", "bit_clk", 32'(bit_clk), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        cfg_width = 2'd0; cfg_two_x = 1'b0; cfg_msb_first = 1'b0;
        ch_words = '1;
        repeat (3) @(posedge clk);
        #2 chk_quiet();
        @(negedge clk);
        next_cfg(0);
        rst = 1'b0;
        for (int f = 0; f < 40; f++) run_frame(f);

        // reset in the middle of a frame, then restart framing
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #2 chk_quiet();
        @(posedge clk); #2 chk_quiet();
        @(negedge clk);
        next_cfg(6);
        rst = 1'b0;
        for (int f = 6; f < 12; f++) run_frame(f);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule